// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM interface. It brings the memory device from power-on to a usable state after reset. First it holds the clock enable and data mask high and keeps the command pins idle for a configurable number of clock cycles. It then closes every bank with a single precharge. After that it runs the auto-refresh phase and the mode-register-set phase, in an order picked by a configuration input. When the last settle time has elapsed it raises a ready flag.

The mode word is built field by field from configuration inputs: CAS latency, burst type, burst length and write-burst behaviour. These inputs are captured once, on the first clock edge after reset. An illegal combination is refused: the block raises an error flag and stays idle, and no device command goes out at all. A tiny timer and a refresh counter pace the phases, so every settle window is a parameter counted in clock cycles.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and during the idle hold afterwards, `sd_cke` and `sd_dqm` are 1, the command pins {cs_n,ras_n,cas_n,we_n} carry NOP (4'b0111), and `sd_addr`/`sd_ba` are 0. At least HOLD_CYCLES NOP cycles appear after reset before the first command.
- R2: The first command is precharge ({cs_n,ras_n,cas_n,we_n}=4'b0010), with address bit 10 at 1, all other address bits at 0 and `sd_ba` at 0, so that every bank is closed.
- R3: Exactly REFRESH_COUNT auto-refresh commands (4'b0001) are issued. Values below 2 are raised to 2.
- R4: With `cfg_mode_first`=0 the order is precharge, then all refreshes, then mode set (4'b0000). With `cfg_mode_first`=1 the order is precharge, then mode set, then all refreshes.
- R5: During mode set the address bus carries burst length on bits 2..0, burst type on bit 3 (1 = interleave), CAS latency on bits 6..4, and single-location write mode on bit 9.
- R6: During mode set, address bits 8..7, all bits above 9, and `sd_ba` are 0.
- R7: Exactly T_RP NOP cycles follow the precharge, T_RC NOP cycles follow each refresh, and T_MRD NOP cycles follow the mode set. In each case the next command comes on the cycle after those NOPs.
- R8: `init_done` rises exactly T of the final command's wait after that command appears on the pins. It then stays high with NOP on the pins until reset.
- R9: A full-page burst length (3'b111) combined with interleave raises `cfg_error`. In that case no command is ever issued and `init_done` stays 0.
- R10: A CAS latency other than 2 or 3, or a burst-length code of 4, 5 or 6, raises `cfg_error` with the same idle behaviour as R9.
- R11: Configuration is sampled on the first clock edge after reset. Changes to the configuration inputs after that edge have no effect on the mode word or on the phase order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_burst_type | input | 1 | 0 sequential, 1 interleave |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_single_write | input | 1 | 1 = burst read, single-location write |
| cfg_mode_first | input | 1 | 1 = mode set before the refresh phase |
| sd_cke | output | 1 | Clock enable to the device |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | 1 | Data mask |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Device ready, sticky until reset |
| cfg_error | output | 1 | Illegal configuration, sticky until reset |

## Verification
The assertions take three things for granted. ADDR_W is at least 11, every timing parameter is at least 1, and reset is held for at least one clock edge, so that the registered pins start out idle. The checker also relies on a mode set only ever carrying legal field codes, which holds only because the configuration is captured once and screened before the hold starts. The stimulus keeps within this: it holds reset for several cycles before each run and drives configurations both legal and illegal. Where it changes the configuration inputs, it does so only after the capture edge, to show they are ignored from then on.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // command pin encoding {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001,
    CMD_MRS = 4'b0000
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_CHECK,
    ST_HOLD,
    ST_PRE,
    ST_WAIT_RP,
    ST_REF,
    ST_WAIT_RC,
    ST_MRS,
    ST_WAIT_MRD,
    ST_READY,
    ST_FAULT
  } init_state_e;

  typedef struct packed {
    logic [2:0] cas;
    logic       bt;
    logic [2:0] bl;
    logic       wb;
    logic       mode_first;
  } init_cfg_t;

  localparam logic [2:0] BL_FULL = 3'b111;
  localparam int         PRE_ALL_BIT = 10;
  localparam int         MODE_BITS = 10;

  function automatic logic cas_legal(input logic [2:0] c);
    return (c == 3'd2) || (c == 3'd3);
  endfunction

  function automatic logic bl_legal(input logic [2:0] b);
    return (b <= 3'd3) || (b == BL_FULL);
  endfunction

  // full page bursts only make sense in sequential order
  function automatic logic combo_legal(input logic [2:0] b, input logic t);
    return !((b == BL_FULL) && t);
  endfunction

  function automatic logic cfg_legal(input init_cfg_t c);
    return cas_legal(c.cas) && bl_legal(c.bl) && combo_legal(c.bl, c.bt);
  endfunction

  function automatic logic [MODE_BITS-1:0] mode_word(input init_cfg_t c);
    logic [MODE_BITS-1:0] w;
    w      = '0;
    w[2:0] = c.bl;
    w[3]   = c.bt;
    w[6:4] = c.cas;
    w[8:7] = 2'b00;
    w[9]   = c.wb;
    return w;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int HOLD_C = 10000,
  parameter int REF_N  = 2,
  parameter int TRP_C  = 3,
  parameter int TRC_C  = 8,
  parameter int TMRD_C = 2,
  parameter int TW     = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  init_cfg_t     cfg_in,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output sd_cmd_e       cmd_req,
  output init_cfg_t     cfg_q,
  output logic          ready,
  output logic          fault
);

  localparam int RCW = $clog2(REF_N + 1);
  localparam logic [TW-1:0]  LD_HOLD = TW'(HOLD_C - 1);
  localparam logic [TW-1:0]  LD_RP   = TW'(TRP_C - 1);
  localparam logic [TW-1:0]  LD_RC   = TW'(TRC_C - 1);
  localparam logic [TW-1:0]  LD_MRD  = TW'(TMRD_C - 1);
  localparam logic [RCW-1:0] REF_LAST = RCW'(REF_N);

  init_state_e    st_q, st_d;
  logic [RCW-1:0] ref_cnt_q;
  logic           refs_done;

  assign refs_done = (ref_cnt_q == REF_LAST);

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cmd_req  = CMD_NOP;
    unique case (st_q)
      ST_CHECK: begin
        if (cfg_legal(cfg_in)) begin
          st_d     = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = LD_HOLD;
        end else begin
          st_d = ST_FAULT;
        end
      end
      ST_HOLD: if (tmr_zero) st_d = ST_PRE;
      ST_PRE: begin
        cmd_req  = CMD_PRE;
        tmr_load = 1'b1;
        tmr_val  = LD_RP;
        st_d     = ST_WAIT_RP;
      end
      ST_WAIT_RP: if (tmr_zero) st_d = cfg_q.mode_first ? ST_MRS : ST_REF;
      ST_REF: begin
        cmd_req  = CMD_REF;
        tmr_load = 1'b1;
        tmr_val  = LD_RC;
        st_d     = ST_WAIT_RC;
      end
      ST_WAIT_RC: begin
        if (tmr_zero) begin
          if (!refs_done)            st_d = ST_REF;
          else if (cfg_q.mode_first) st_d = ST_READY;
          else                       st_d = ST_MRS;
        end
      end
      ST_MRS: begin
        cmd_req  = CMD_MRS;
        tmr_load = 1'b1;
        tmr_val  = LD_MRD;
        st_d     = ST_WAIT_MRD;
      end
      ST_WAIT_MRD: if (tmr_zero) st_d = cfg_q.mode_first ? ST_REF : ST_READY;
      ST_READY: st_d = ST_READY;
      ST_FAULT: st_d = ST_FAULT;
      default:  st_d = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_CHECK;
      ref_cnt_q <= '0;
      cfg_q     <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_CHECK) cfg_q <= cfg_in;
      if (st_q == ST_REF)   ref_cnt_q <= ref_cnt_q + 1'b1;
    end
  end

  assign ready = (st_q == ST_READY);
  assign fault = (st_q == ST_FAULT);

endmodule

// File: rtl/sdram_init_cmd_drv.sv
module sdram_init_cmd_drv
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  sd_cmd_e              cmd_req,
  input  logic [MODE_BITS-1:0] mode_bits,
  output logic                 cs_n,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic [1:0]           ba,
  output logic [ADDR_W-1:0]    addr,
  output logic                 cke,
  output logic                 dqm
);

  function automatic logic [ADDR_W-1:0] addr_for(input sd_cmd_e c,
                                                 input logic [MODE_BITS-1:0] m);
    logic [ADDR_W-1:0] a;
    a = '0;
    if (c == CMD_PRE) a[PRE_ALL_BIT] = 1'b1;
    else if (c == CMD_MRS) a[MODE_BITS-1:0] = m;
    return a;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
      ba   <= '0;
      addr <= '0;
      cke  <= 1'b1;
      dqm  <= 1'b1;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= cmd_req;
      ba   <= '0;
      addr <= addr_for(cmd_req, mode_bits);
      cke  <= 1'b1;
      dqm  <= 1'b1;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int HOLD_CYCLES   = 10000,
  parameter int REFRESH_COUNT = 2,
  parameter int T_RP          = 3,
  parameter int T_RC          = 8,
  parameter int T_MRD         = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_burst_type,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_single_write,
  input  logic              cfg_mode_first,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_dqm,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done,
  output logic              cfg_error
);

  localparam int REF_N  = max_of(REFRESH_COUNT, 2);
  localparam int HOLD_C = max_of(HOLD_CYCLES, 1);
  localparam int TRP_C  = max_of(T_RP, 1);
  localparam int TRC_C  = max_of(T_RC, 1);
  localparam int TMRD_C = max_of(T_MRD, 1);
  localparam int MAXT   = max_of(max_of(HOLD_C, TRP_C), max_of(TRC_C, TMRD_C));
  localparam int TW     = $clog2(MAXT + 1);

  init_cfg_t            cfg_in, cfg_q;
  logic                 tmr_load, tmr_zero;
  logic [TW-1:0]        tmr_val;
  sd_cmd_e              cmd_req;
  logic [MODE_BITS-1:0] mode_bits;

  assign cfg_in = '{cas: cfg_cas_lat, bt: cfg_burst_type, bl: cfg_burst_len,
                    wb: cfg_single_write, mode_first: cfg_mode_first};
  assign mode_bits = mode_word(cfg_q);

  sdram_init_fsm #(
    .HOLD_C(HOLD_C), .REF_N(REF_N), .TRP_C(TRP_C),
    .TRC_C(TRC_C), .TMRD_C(TMRD_C), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .cmd_req(cmd_req),
    .cfg_q(cfg_q), .ready(init_done), .fault(cfg_error)
  );

  sdram_init_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .zero(tmr_zero)
  );

  sdram_init_cmd_drv #(.ADDR_W(ADDR_W)) u_drv (
    .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .mode_bits(mode_bits),
    .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .ba(sd_ba), .addr(sd_addr), .cke(sd_cke), .dqm(sd_dqm)
  );

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              dqm,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic              done,
  input logic              err
);

  logic [3:0] pins;
  logic       is_nop, is_pre, is_mrs;
  assign pins   = {cs_n, ras_n, cas_n, we_n};
  assign is_nop = (pins == 4'(CMD_NOP));
  assign is_pre = (pins == 4'(CMD_PRE));
  assign is_mrs = (pins == 4'(CMD_MRS));

  // R1
  cke_dqm_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke && dqm);

  // R2
  pre_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (addr == ADDR_W'(1 << PRE_ALL_BIT)) && (ba == 2'b00));

  // R6
  mrs_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (ba == 2'b00) && (addr[8:7] == 2'b00) && ((addr >> MODE_BITS) == '0));

  // R5
  mrs_fields_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> cas_legal(addr[6:4]) && bl_legal(addr[2:0]) && combo_legal(addr[2:0], addr[3]));

  // R7
  cmd_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |=> is_nop);

  // R8
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R8
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> is_nop);

  // R9
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> is_nop && !done);

  // R10
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

bind sdram_init_seq sdram_init_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(sd_cke), .dqm(sd_dqm), .cs_n(sd_cs_n),
  .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n), .ba(sd_ba),
  .addr(sd_addr), .done(init_done), .err(cfg_error)
);

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;
  localparam int AW = 12, HOLD = 40, NREF = 3, TRP = 3, TRC = 5, TMRD = 2;
  localparam int LIMIT = 160;
  localparam int K_NOP = 7, K_PRE = 2, K_REF = 1, K_MRS = 0;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic [2:0] cas_i = 3'd2, bl_i = 3'd0;
  logic bt_i = 1'b0, wb_i = 1'b0, mf_i = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, dqm, done, err;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  sdram_init_seq #(.ADDR_W(AW), .HOLD_CYCLES(HOLD), .REFRESH_COUNT(NREF),
                   .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cas_i), .cfg_burst_type(bt_i),
    .cfg_burst_len(bl_i), .cfg_single_write(wb_i), .cfg_mode_first(mf_i),
    .sd_cke(cke), .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n),
    .sd_we_n(we_n), .sd_dqm(dqm), .sd_ba(ba), .sd_addr(addr),
    .init_done(done), .cfg_error(err));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ok(input int c, input int t, input int b);
    if (c != 2 && c != 3) return 1'b0;
    if (b == 7) return (t == 0);
    return (b < 4);
  endfunction

  function automatic int exp_word(input int c, input int t, input int b, input int w);
    return w * 512 + c * 16 + t * 8 + b;
  endfunction

  function automatic int exp_kind(input int i, input int mf);
    if (i == 0) return K_PRE;
    if (mf == 0) return (i == NREF + 1) ? K_MRS : K_REF;
    return (i == 1) ? K_MRS : K_REF;
  endfunction

  function automatic int wait_of(input int k);
    if (k == K_PRE) return TRP;
    if (k == K_REF) return TRC;
    return TMRD;
  endfunction

  task automatic run(input int c, input int t, input int b, input int w,
                     input int mf, input bit mutate);
    int kind [0:15];
    int cyc [0:15];
    int ad [0:15];
    int bk [0:15];
    int n = 0, done_at = -1, low = 0;
    bit drop = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    cas_i = 3'(c); bt_i = 1'(t); bl_i = 3'(b); wb_i = 1'(w); mf_i = 1'(mf);
    repeat (3) @(negedge clk);
    check(cke && dqm && {cs_n, ras_n, cas_n, we_n} == 4'b0111 && addr == '0
          && ba == '0 && !done && !err, "R1", "reset pins",
          int'({cke, dqm, cs_n, ras_n, cas_n, we_n}), 6'b110111);
    rst_n = 1'b1;
    for (int cy = 1; cy <= LIMIT; cy++) begin
      @(negedge clk);
      if (mutate && cy == 3) begin
        // R11: inputs change after the capture edge
        cas_i = 3'($urandom % 8); bt_i = 1'($urandom); bl_i = 3'($urandom % 8);
        wb_i = 1'($urandom); mf_i = 1'($urandom);
      end
      if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
        if (n < 16) begin
          kind[n] = int'({cs_n, ras_n, cas_n, we_n});
          cyc[n] = cy; ad[n] = int'(addr); bk[n] = int'(ba);
        end
        n++;
      end
      if (done && done_at < 0) done_at = cy;
      if (done_at >= 0 && !done) drop = 1'b1;
      if (!cke || !dqm) low++;
    end
    check(low == 0, "R1", "cke/dqm low cycles", low, 0);
    if (!exp_ok(c, t, b)) begin
      // R9 / R10: illegal configuration
      check(err == 1'b1, (b == 7 && t == 1) ? "R9" : "R10", "cfg_error", int'(err), 1);
      check(n == 0, (b == 7 && t == 1) ? "R9" : "R10", "commands issued", n, 0);
      check(done_at < 0, "R10", "ready cycle", done_at, -1);
      return;
    end
    check(err == 1'b0, "R10", "cfg_error on legal cfg", int'(err), 0);
    check(n == NREF + 2, "R3", "command count", n, NREF + 2);
    if (n != NREF + 2) return;
    check(cyc[0] - 1 >= HOLD, "R1", "hold NOP cycles", cyc[0] - 1, HOLD);
    check(ad[0] == 1024 && bk[0] == 0, "R2", "precharge address", ad[0], 1024);
    for (int i = 0; i < n; i++) begin
      check(kind[i] == exp_kind(i, mf), "R4", "command order", kind[i], exp_kind(i, mf));
      if (kind[i] == K_MRS) begin
        check(ad[i] == exp_word(c, t, b, w), "R5", "mode word", ad[i], exp_word(c, t, b, w));
        check(bk[i] == 0, "R6", "mode bank bits", bk[i], 0);
      end
      if (i > 0)
        check(cyc[i] - cyc[i-1] == wait_of(kind[i-1]) + 1, "R7", "command gap",
              cyc[i] - cyc[i-1], wait_of(kind[i-1]) + 1);
    end
    check(done_at - cyc[n-1] == wait_of(kind[n-1]), "R8", "ready delay",
          done_at - cyc[n-1], wait_of(kind[n-1]));
    check(!drop, "R8", "ready dropped", int'(drop), 0);
    if (mutate) check(ad[mf ? 1 : n-1] == exp_word(c, t, b, w), "R11",
                      "mode word after input change", ad[mf ? 1 : n-1], exp_word(c, t, b, w));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    run(2, 0, 3, 0, 0, 1'b0);
    run(3, 0, 7, 1, 1, 1'b0);
    run(2, 1, 2, 0, 1, 1'b1);
    run(3, 1, 7, 0, 0, 1'b0);
    run(1, 0, 2, 0, 0, 1'b0);
    run(2, 0, 5, 0, 1, 1'b0);
    for (int r = 0; r < 24; r++) begin
      int c, t, b;
      c = ($urandom % 4 == 0) ? int'($urandom % 8) : 2 + int'($urandom % 2);
      t = int'($urandom % 2);
      b = ($urandom % 4 == 0) ? int'($urandom % 8) : int'($urandom % 4);
      if ($urandom % 5 == 0) b = 7;
      run(c, t, b, int'($urandom % 2), int'($urandom % 2), 1'($urandom));
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule